// File: doc/BRIEF.md
# Debug Monitor Entry Decision

This block runs once per power-on. When the power-on sequence signals it is finished, the block looks at three things: the high-voltage detector on the interrupt pin, the two bytes stored at the reset-vector location, and a clock-select pin. From these it decides whether the device starts in user mode or in debug monitor mode. It also picks how the clock is divided, so that the serial monitor link always runs at the same baud rate.

There are two ways into monitor mode. The first applies a high voltage to the interrupt pin; the stored vector does not matter on this path. Here the clock-select pin tells the block which crystal is fitted. Low means a 4 MHz crystal, used undivided. High means an 8 MHz crystal, halved. The second way needs no high voltage: it is taken when both vector bytes read as erased (0xFF). This path assumes an 8 MHz crystal, so the clock is always halved. On this path the logic level of the interrupt pin is ignored.

The decision is taken on the clock edge that samples the done strobe. It is then held until the next reset. A separate flag marks a blank-vector entry, so that security logic further on can treat an erased part on its own terms. The block has five states: WAIT, USER, MON_HV_DIV1, MON_HV_DIV2 and MON_BLANK. Reset enters WAIT. WAIT moves on a done strobe:
- to MON_HV_DIV1 when high voltage is present and clock-select is low;
- to MON_HV_DIV2 when high voltage is present and clock-select is high;
- otherwise to MON_BLANK when both vector bytes are erased;
- otherwise to USER.

The other four states are terminal and hold until reset.

Top module: `mon_entry_top`

## Requirements
- R1: While reset is active, and after reset until the first done strobe has been sampled, mon_mode, blank_entry and div2_sel are all 0.
- R2: If irq_hv is 1 when the strobe is sampled, mon_mode becomes 1 and blank_entry stays 0, whatever the vector bytes hold.
- R3: On the high-voltage path with clk_sel = 0, div2_sel is 0 (no extra division).
- R4: On the high-voltage path with clk_sel = 1, div2_sel is 1 (extra divide by two).
- R5: If irq_hv is 0 and vec_hi = vec_lo = 8'hFF when the strobe is sampled, mon_mode, blank_entry and div2_sel all become 1.
- R6: On the blank-vector path, neither irq_lvl nor clk_sel changes any output.
- R7: If irq_hv is 0 and the vector is not blank, all three outputs stay 0 (user mode).
- R8: If only one of the two vector bytes equals 8'hFF, the vector counts as programmed, not blank.
- R9: After the first strobe, later strobes and any change on the inputs leave the outputs unchanged until reset.
- R10: The outputs take their new values right after the rising edge that samples por_done = 1. They are unchanged before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_done | input | 1 | Strobe that marks the end of the power-on reset |
| vec_hi | input | 8 | Reset-vector byte at the highest address |
| vec_lo | input | 8 | Reset-vector byte just below it |
| irq_hv | input | 1 | High-voltage detect flag for the interrupt pin |
| irq_lvl | input | 1 | Logic level on the interrupt pin |
| clk_sel | input | 1 | Clock-select pin for the crystal frequency |
| mon_mode | output | 1 | Device is in debug monitor mode |
| blank_entry | output | 1 | Monitor mode was entered through the blank-vector path |
| div2_sel | output | 1 | Apply an extra divide by two to the clock |

## Verification
The hardest condition to reach is the freeze. Once a decision is taken, the block must ignore a second done strobe, even one that arrives with inputs that would have chosen a different path. The directed test first enters user mode, then applies high voltage and an erased vector and strobes again. It checks that the outputs do not move, and only then resets and confirms that a fresh strobe is accepted. A per-byte mismatch also needs care: the vector table includes cases where just one byte is 0xFF, so a check that looks at only one byte would be caught.

// File: rtl/mon_entry_pkg.sv
package mon_entry_pkg;

    typedef enum logic [2:0] {
        ST_WAIT        = 3'd0,
        ST_USER        = 3'd1,
        ST_MON_HV_DIV1 = 3'd2,
        ST_MON_HV_DIV2 = 3'd3,
        ST_MON_BLANK   = 3'd4
    } mon_state_e;

endpackage

// File: rtl/mon_blank_det.sv
module mon_blank_det #(
    parameter int WORD_W    = 8,
    parameter int NUM_WORDS = 2
) (
    input  logic [NUM_WORDS-1:0][WORD_W-1:0] words,
    output logic                             is_blank
);
    localparam logic [WORD_W-1:0] ERASED = {WORD_W{1'b1}};

    logic [NUM_WORDS-1:0] word_erased;

    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
        assign word_erased[g] = (words[g] == ERASED);
    end

    assign is_blank = &word_erased;
endmodule

// File: rtl/mon_entry_fsm.sv
module mon_entry_fsm
    import mon_entry_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic por_done,
    input  logic irq_hv,
    input  logic clk_sel,
    input  logic is_blank,
    output logic mon_mode,
    output logic blank_entry,
    output logic div2_sel
);
    mon_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_WAIT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT: begin
                if (por_done) begin
                    if (irq_hv)        state_d = clk_sel ? ST_MON_HV_DIV2 : ST_MON_HV_DIV1;
                    else if (is_blank) state_d = ST_MON_BLANK;
                    else               state_d = ST_USER;
                end
            end
            ST_USER, ST_MON_HV_DIV1, ST_MON_HV_DIV2, ST_MON_BLANK: state_d = state_q;
            default: state_d = ST_WAIT;
        endcase
    end

    always_comb begin
        mon_mode    = 1'b0;
        blank_entry = 1'b0;
        div2_sel    = 1'b0;
        unique case (state_q)
            ST_WAIT, ST_USER: ;
            ST_MON_HV_DIV1: mon_mode = 1'b1;
            ST_MON_HV_DIV2: begin
                mon_mode = 1'b1;
                div2_sel = 1'b1;
            end
            ST_MON_BLANK: begin
                mon_mode    = 1'b1;
                blank_entry = 1'b1;
                div2_sel    = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/mon_entry_top.sv
module mon_entry_top #(
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             por_done,
    input  logic [VEC_W-1:0] vec_hi,
    input  logic [VEC_W-1:0] vec_lo,
    input  logic             irq_hv,
    input  logic             irq_lvl,
    input  logic             clk_sel,
    output logic             mon_mode,
    output logic             blank_entry,
    output logic             div2_sel
);
    localparam int VEC_WORDS = 2;

    logic [VEC_WORDS-1:0][VEC_W-1:0] vec_words;
    logic                            vec_blank;
    logic                            unused_irq_lvl;

    // The pin level plays no part in the decision on either path.
    assign unused_irq_lvl = irq_lvl;
    assign vec_words      = {vec_hi, vec_lo};

    mon_blank_det #(.WORD_W(VEC_W), .NUM_WORDS(VEC_WORDS)) u_blank (
        .words    (vec_words),
        .is_blank (vec_blank)
    );

    mon_entry_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .por_done    (por_done),
        .irq_hv      (irq_hv),
        .clk_sel     (clk_sel),
        .is_blank    (vec_blank),
        .mon_mode    (mon_mode),
        .blank_entry (blank_entry),
        .div2_sel    (div2_sel)
    );
endmodule

// File: rtl/mon_entry_chk.sv
module mon_entry_chk #(
    parameter int VEC_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             por_done,
    input logic [VEC_W-1:0] vec_hi,
    input logic [VEC_W-1:0] vec_lo,
    input logic             irq_hv,
    input logic             clk_sel,
    input logic             mon_mode,
    input logic             blank_entry,
    input logic             div2_sel
);
    logic decided;
    logic erased;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        decided <= 1'b0;
        else if (por_done) decided <= 1'b1;
    end

    assign erased = (&vec_hi) && (&vec_lo);

    // R1
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !decided |-> (!mon_mode && !blank_entry && !div2_sel));

    // R2
    hv_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (por_done && !decided && irq_hv) |=> (mon_mode && !blank_entry));

    // R3
    hv_div1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (por_done && !decided && irq_hv && !clk_sel) |=> !div2_sel);

    // R4
    hv_div2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (por_done && !decided && irq_hv && clk_sel) |=> div2_sel);

    // R5
    blank_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (por_done && !decided && !irq_hv && erased) |=> (mon_mode && blank_entry && div2_sel));

    // R7
    user_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (por_done && !decided && !irq_hv && !erased) |=> (!mon_mode && !blank_entry && !div2_sel));

    // R9
    frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        decided |=> ($stable(mon_mode) && $stable(blank_entry) && $stable(div2_sel)));
endmodule

bind mon_entry_top mon_entry_chk #(.VEC_W(VEC_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .por_done    (por_done),
    .vec_hi      (vec_hi),
    .vec_lo      (vec_lo),
    .irq_hv      (irq_hv),
    .clk_sel     (clk_sel),
    .mon_mode    (mon_mode),
    .blank_entry (blank_entry),
    .div2_sel    (div2_sel)
);

// File: tb/sim_mon_entry_top.sv
module sim_mon_entry_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       por_done = 1'b0;
    logic [7:0] vec_hi = 8'h00;
    logic [7:0] vec_lo = 8'h00;
    logic       irq_hv = 1'b0;
    logic       irq_lvl = 1'b0;
    logic       clk_sel = 1'b0;
    logic       mon_mode, blank_entry, div2_sel;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    mon_entry_top u0 (
        .clk(clk), .rst_n(rst_n), .por_done(por_done),
        .vec_hi(vec_hi), .vec_lo(vec_lo), .irq_hv(irq_hv),
        .irq_lvl(irq_lvl), .clk_sel(clk_sel),
        .mon_mode(mon_mode), .blank_entry(blank_entry), .div2_sel(div2_sel)
    );

    // {irq_hv, irq_lvl, clk_sel, vec_hi, vec_lo, exp_mon, exp_blank, exp_div2}
    localparam int NV = 9;
    localparam logic [21:0] VECS [NV] = '{
        {1'b1, 1'b1, 1'b0, 8'hFF, 8'hFF, 1'b1, 1'b0, 1'b0}, // R2 R3
        {1'b1, 1'b1, 1'b1, 8'h12, 8'h34, 1'b1, 1'b0, 1'b1}, // R2 R4
        {1'b1, 1'b0, 1'b0, 8'h00, 8'h40, 1'b1, 1'b0, 1'b0}, // R3
        {1'b0, 1'b1, 1'b0, 8'hFF, 8'hFF, 1'b1, 1'b1, 1'b1}, // R5 R6
        {1'b0, 1'b0, 1'b1, 8'hFF, 8'hFF, 1'b1, 1'b1, 1'b1}, // R5 R6
        {1'b0, 1'b1, 1'b0, 8'hFF, 8'hFE, 1'b0, 1'b0, 1'b0}, // R8
        {1'b0, 1'b0, 1'b1, 8'h7F, 8'hFF, 1'b0, 1'b0, 1'b0}, // R8
        {1'b0, 1'b1, 1'b1, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0}, // R7
        {1'b1, 1'b0, 1'b1, 8'hFF, 8'hFF, 1'b1, 1'b0, 1'b1}  // R2 R4
    };

    task automatic check_out(input string req, input logic [2:0] exp);
        n_checks++;
        if ({mon_mode, blank_entry, div2_sel} !== exp) begin
            n_errors++;
            $display("FAIL %s: outputs {mon,blank,div2}=%b expected %b",
                     req, {mon_mode, blank_entry, div2_sel}, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        por_done = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic strobe();
        por_done = 1'b1;
        @(negedge clk);
        por_done = 1'b0;
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        // R1: during reset
        repeat (2) @(negedge clk);
        check_out("R1 in reset", 3'b000);

        for (int i = 0; i < NV; i++) begin
            do_reset();
            {irq_hv, irq_lvl, clk_sel, vec_hi, vec_lo} = VECS[i][21:3];
            @(negedge clk);
            check_out("R1 before strobe", 3'b000);
            strobe();
            check_out($sformatf("R2-R8 vector %0d", i), VECS[i][2:0]);
        end

        // R10: no change before the sampling edge, change right after it
        do_reset();
        irq_hv = 1'b1; clk_sel = 1'b1; vec_hi = 8'h00; vec_lo = 8'h00;
        por_done = 1'b1;
        #1;
        check_out("R10 before edge", 3'b000);
        @(posedge clk);
        #1;
        check_out("R10 after edge", 3'b101);
        @(negedge clk);
        por_done = 1'b0;

        // R9: user mode held against a later strobe that would choose monitor mode
        do_reset();
        irq_hv = 1'b0; vec_hi = 8'h01; vec_lo = 8'hFF;
        strobe();
        check_out("R9 user decided", 3'b000);
        irq_hv = 1'b1; clk_sel = 1'b1; vec_hi = 8'hFF; vec_lo = 8'hFF;
        strobe();
        repeat (3) @(negedge clk);
        check_out("R9 second strobe ignored", 3'b000);
        irq_hv = 1'b0;
        strobe();
        check_out("R9 blank strobe ignored", 3'b000);

        // R9: blank entry held while inputs move
        do_reset();
        irq_hv = 1'b0; clk_sel = 1'b0; vec_hi = 8'hFF; vec_lo = 8'hFF;
        strobe();
        check_out("R5 blank decided", 3'b111);
        vec_hi = 8'h00; irq_hv = 1'b1; irq_lvl = ~irq_lvl;
        strobe();
        check_out("R9 blank frozen", 3'b111);

        // R1: reset clears a held decision
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check_out("R1 async reset clears", 3'b000);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_out("R1 after reset release", 3'b000);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule